// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block recovers asynchronous serial frames from a single line. It is built as a controller plus datapath. Everything runs on one system clock that is never gated. A one-cycle enable pulse, supplied from outside at sixteen times the bit rate, marks the only cycles in which the line is looked at and in which any state moves.

The block finds the falling edge of a start bit and confirms the start bit at its middle. It then takes one sample at the centre of each following bit period. Nine samples, eight data bits followed by a parity bit, are shifted into a single register. When the ninth sample lands, the word is copied to the output and a one-clock ready strobe is raised.

Baud generation, parity checking and any bus interface belong to the surrounding logic. The parity bit is handed over unchecked in the top position of the word.

Top module: `uart_rx`

## Requirements
- R1: While rst_ni is low, and right after it is released, data_o reads 0 and ready_o reads 0.
- R2: State advances only on clock edges where tick_i is high. A low excursion of rx_i that begins and ends between two tick_i pulses produces no ready_o and leaves data_o unchanged.
- R3: A start bit is accepted only if rx_i is still 0 on the eighth tick counted from the first tick that saw 0. If rx_i has returned to 1 by then, the block goes back to idle with no ready_o and no change to data_o.
- R4: After an accepted start bit, each of the nine following bits is sampled 16 ticks after the previous sample. The first bit received appears on data_o[0] and the ninth (parity) bit on data_o[8].
- R5: Each complete frame raises ready_o for exactly one system clock, in the cycle right after the tick that samples the ninth bit. data_o already holds the new word in that cycle.
- R6: data_o holds its value from one ready_o strobe until the next, including while a later frame is being received.
- R7: Frames sent back to back, each with one stop bit of 16 ticks at 1, are all received in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_i | input | 1 | Serial line, idles at 1 |
| data_o | output | 9 | Last received word; bit 8 is the parity bit |
| ready_o | output | 1 | One-clock strobe when a frame completes |

## Verification
Frames are sent with alternating, all-zero, all-one and sparse bit patterns. Together these separate a correct sampling point and bit order from off-by-one shifts or reversed ordering. A start pulse shorter than half a bit tests the mid-bit check. Line pulses that fall entirely between enable pulses show whether anything responds to the line outside enable cycles. Back-to-back frames are sent with data_o compared midway through the next frame, which exposes early overwrites of the held word and missed restarts after the stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DONE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_subcnt.sv
module uart_rx_subcnt #(
  parameter int unsigned OVS = 16,
  localparam int unsigned W  = $clog2(OVS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         at_zero_o,
  output logic         at_mid_o,
  output logic         at_last_o
);
  localparam logic [W-1:0] MID  = W'(OVS / 2 - 1);
  localparam logic [W-1:0] LAST = W'(OVS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign at_zero_o = (cnt_q == '0);
  assign at_mid_o  = (cnt_q == MID);
  assign at_last_o = (cnt_q == LAST);
endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath #(
  parameter int unsigned NBITS = 9,
  localparam int unsigned BW   = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             bit_clr_i,
  input  logic             shift_i,
  input  logic             load_i,
  output logic             bit_last_o,
  output logic [NBITS-1:0] data_o
);
  localparam logic [BW-1:0] LAST = BW'(NBITS - 1);

  logic [NBITS-1:0] shreg_q;
  logic [NBITS-1:0] hold_q;
  logic [BW-1:0]    bit_cnt_q;
  logic [NBITS-1:0] shreg_nxt;

  // new sample enters at the top, older samples move toward bit 0
  assign shreg_nxt = {rx_i, shreg_q[NBITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shreg_q <= '0;
    else if (shift_i) shreg_q <= shreg_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_cnt_q <= '0;
    else if (bit_clr_i) bit_cnt_q <= '0;
    else if (shift_i)   bit_cnt_q <= bit_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= shreg_nxt;
  end

  assign bit_last_o = (bit_cnt_q == LAST);
  assign data_o     = hold_q;
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic sub_zero_i,
  input  logic sub_mid_i,
  input  logic sub_last_i,
  input  logic bit_last_i,
  output logic sub_clr_o,
  output logic sub_inc_o,
  output logic bit_clr_o,
  output logic shift_o,
  output logic load_o,
  output logic ready_o
);
  rx_state_e state_q, state_d;
  logic      ready_q;
  logic      finish;

  always_comb begin
    state_d   = state_q;
    sub_clr_o = 1'b0;
    sub_inc_o = 1'b0;
    bit_clr_o = 1'b0;
    shift_o   = 1'b0;
    finish    = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          bit_clr_o = 1'b1;
          if (sub_zero_i && rx_i) begin
            sub_clr_o = 1'b1;
          end else if (sub_mid_i) begin
            sub_clr_o = 1'b1;
            if (!rx_i) state_d = ST_RECV;
          end else begin
            sub_inc_o = 1'b1;
          end
        end
        ST_RECV: begin
          sub_inc_o = 1'b1;
          if (sub_last_i) begin
            shift_o = 1'b1;
            if (bit_last_i) begin
              finish  = 1'b1;
              state_d = ST_DONE;
            end
          end
        end
        ST_DONE: begin
          sub_clr_o = 1'b1;
          bit_clr_o = 1'b1;
          state_d   = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign load_o = finish;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= finish;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned NBITS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  output logic [NBITS-1:0] data_o,
  output logic             ready_o
);
  localparam int unsigned SW = $clog2(OVS);

  logic          sub_clr, sub_inc, bit_clr, shift, load;
  logic          sub_zero, sub_mid, sub_last, bit_last;
  logic [SW-1:0] sub_cnt;
  logic          unused_cnt;

  uart_rx_subcnt #(.OVS(OVS)) u_subcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sub_clr),
    .inc_i     (sub_inc),
    .cnt_o     (sub_cnt),
    .at_zero_o (sub_zero),
    .at_mid_o  (sub_mid),
    .at_last_o (sub_last)
  );

  assign unused_cnt = ^sub_cnt;

  uart_rx_datapath #(.NBITS(NBITS)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .bit_clr_i  (bit_clr),
    .shift_i    (shift),
    .load_i     (load),
    .bit_last_o (bit_last),
    .data_o     (data_o)
  );

  uart_rx_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_i       (rx_i),
    .sub_zero_i (sub_zero),
    .sub_mid_i  (sub_mid),
    .sub_last_i (sub_last),
    .bit_last_i (bit_last),
    .sub_clr_o  (sub_clr),
    .sub_inc_o  (sub_inc),
    .bit_clr_o  (bit_clr),
    .shift_o    (shift),
    .load_o     (load),
    .ready_o    (ready_o)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int unsigned NBITS = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [NBITS-1:0] data_o,
  input logic             ready_o
);
  // R5: strobe lasts one clock
  a_r5_ready_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R5: strobe follows an enable cycle
  a_r5_ready_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(tick_i));

  // R2: nothing moves on an edge without the enable
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!ready_o && $stable(data_o)));

  // R6: output word changes only alongside the strobe
  a_r6_data_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> ready_o);
endmodule

bind uart_rx uart_rx_chk #(.NBITS(NBITS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .data_o  (data_o),
  .ready_o (ready_o)
);

// File: tb/uart_rx_tb_top.sv
module uart_rx_tb_top;
  localparam int OVS   = 16;
  localparam int NBITS = 9;
  localparam int DIV   = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic             rx_i = 1'b1;
  logic [NBITS-1:0] data_o;
  logic             ready_o;

  int checks = 0;
  int errors = 0;
  int ready_seen = 0;
  logic [NBITS-1:0] exp_q[$];
  logic             ready_prev = 1'b0;
  bit               done = 1'b0;

  uart_rx #(.OVS(OVS), .NBITS(NBITS)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
    .rx_i (rx_i), .data_o (data_o), .ready_o (ready_o)
  );

  always #2 clk_i = ~clk_i;

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk_i);
      tick_i = (c == 0);
      c = (c == DIV - 1) ? 0 : c + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk_i); while (!tick_i);
    end
    @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [NBITS-1:0] w);
    exp_q.push_back(w);
    rx_i = 1'b0;
    wait_ticks(OVS);
    for (int b = 0; b < NBITS; b++) begin
      rx_i = w[b];
      wait_ticks(OVS);
    end
    rx_i = 1'b1;
    wait_ticks(OVS);
  endtask

  // monitor: pop expected word on each strobe
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ready_o && ready_prev) begin
        errors++; checks++;
        $display("FAIL R5 actual=ready held 2 cycles expected=1 cycle");
      end
      if (ready_o) begin
        ready_seen++;
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R3 actual=unexpected ready data=%0h expected=no ready", data_o);
        end else begin
          check("R4", 32'(data_o), 32'(exp_q.pop_front()));
        end
      end
    end
    ready_prev = ready_o;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [NBITS-1:0] held;
    int rs;
    repeat (5) @(negedge clk_i);
    check("R1", 32'(data_o), 0);
    check("R1", 32'(ready_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 32'(data_o), 0);
    check("R1", 32'(ready_o), 0);
    wait_ticks(20);

    // R4: several patterns
    send_frame(9'h155);
    send_frame(9'h0AA);
    send_frame(9'h000);
    send_frame(9'h1FF);
    send_frame(9'h101);
    check("R4", 32'(exp_q.size()), 0);

    // R3: start pulse too short is rejected
    held = data_o; rs = ready_seen;
    rx_i = 1'b0; wait_ticks(5);
    rx_i = 1'b1; wait_ticks(40);
    check("R3", 32'(ready_seen), 32'(rs));
    check("R3", 32'(data_o), 32'(held));
    send_frame(9'h0C3);
    check("R3", 32'(ready_seen), 32'(rs + 1));

    // R2: line pulses between enable pulses are ignored
    held = data_o; rs = ready_seen;
    for (int k = 0; k < 20; k++) begin
      do @(posedge clk_i); while (!tick_i);
      @(negedge clk_i);
      rx_i = 1'b0;
      repeat (2) @(negedge clk_i);
      rx_i = 1'b1;
    end
    wait_ticks(30);
    check("R2", 32'(ready_seen), 32'(rs));
    check("R2", 32'(data_o), 32'(held));

    // R6 / R7: back to back, word held mid-frame
    held = data_o;
    fork
      begin
        send_frame(9'h03C);
        send_frame(9'h1E1);
        send_frame(9'h092);
      end
      begin
        wait_ticks(OVS * 5);
        check("R6", 32'(data_o), 32'(held));
        wait_ticks(OVS * 11);
        check("R6", 32'(data_o), 32'h03C);
      end
    join
    check("R7", 32'(exp_q.size()), 0);
    check("R7", 32'(data_o), 32'h092);
    check("R5", 32'(ready_seen), 32'(rs + 3));

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule